// File: doc/BRIEF.md
# Program-Memory Parity Safe-Mode Supervisor

This block sits beside the internal program memory of a multi-channel power controller. It checks even parity on every memory read that carries a valid strobe. When the parity monitor is armed and a read comes back corrupt, the block enters a restricted safe mode. Channels that were delivering power at that moment keep their enable gate and stay powered. Every other channel has its operating-mode field forced to OFF and is held unpowerable for as long as safe mode lasts. A sticky fault flag records the event, and it outlives the safe mode.

A small host register port gives access to the control bits, the fault flag, the channel modes, the channel remap and power-allocation settings, and a firmware revision readback. While safe mode lasts, the revision readback returns all ones. The host may only touch the control and fault registers; writes to any other address are dropped and counted. Safe mode ends when the host sets the memory-enable bit again, or when reset is applied. The analog protections (disconnect, foldback, undervoltage, thermal) live elsewhere and are never gated by this block.

Top module: `safemode_sup`

## Requirements
- R1: With the parity-arm bit (bit 1 of control address 0x60) set, a read with `mem_rd_vld` high and odd ones-count over {`mem_rd_data`, `mem_rd_par`} enters safe mode on the next clock edge.
- R2: A parity mismatch has no effect when the parity-arm bit is clear or `mem_rd_vld` is low.
- R3: On a fault, the memory-enable bit (bit 0 of 0x60) is cleared, the fault flag (bit 0 of 0x0A) is set, and `safe_mode` goes high.
- R4: A read of address 0x41 returns 0xFF while in safe mode and the parameter `FW_REV` otherwise.
- R5: At fault entry, each channel that is powered keeps `ch_en` high. Each channel that is unpowered has its 2-bit field in 0x12 (channel i at bits 2i+1:2i, 00 = OFF) forced to 00, and its `ch_en` held low. Changes on `ch_pwr` during safe mode do not alter `ch_en`.
- R6: The remap register (0x26) and the allocation register (0x29) keep their values across entry into and exit from safe mode.
- R7: Safe mode ends only after a host write to 0x60 with bit 0 set, and a fault in that same cycle keeps the block in safe mode.
- R8: The fault flag stays set after safe mode ends. Writing 1 to bit 0 of 0x0A clears it, writing 0 leaves it, and a fault in the same cycle as a clear leaves it set.
- R9: In safe mode, host writes to any address other than 0x60 and 0x0A are ignored, and each one increments `rej_cnt`, which saturates.
- R10: Reset puts the block in these states: not in safe mode, fault flag 0, control 0x00, all channel modes OFF, all `ch_en` high, remap 0xE4, allocation 0x00, `rej_cnt` 0.
- R11: `host_rdata` is registered and shows the register selected by `host_addr` one clock edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power-on) |
| host_addr | input | 8 | Host register address |
| host_wdata | input | DATA_W | Host write data |
| host_we | input | 1 | Host write enable |
| host_rdata | output | DATA_W | Registered host read data |
| mem_rd_data | input | DATA_W | Program memory read word |
| mem_rd_par | input | 1 | Even parity bit for the read word |
| mem_rd_vld | input | 1 | Read word valid strobe |
| ch_pwr | input | NUM_CH | Per-channel powered status |
| ch_mode | output | 2*NUM_CH | Per-channel operating mode fields |
| ch_en | output | NUM_CH | Per-channel permission to power |
| safe_mode | output | 1 | Safe mode active |
| rej_cnt | output | REJ_W | Count of rejected writes in safe mode |

## Verification
The bench builds the block with its defaults: four channels, 8-bit data, `FW_REV` = 0x3A and a 4-bit rejected-write counter. Four channels make the 8-bit mode register full, so a mixed powered/unpowered pattern checks the forcing of every field position. The narrow counter lets the bench drive the count to saturation with a short burst of rejected writes. A revision value other than 0xFF keeps the safe-mode substitution visible in both directions.

// File: rtl/sm_pkg.sv
package sm_pkg;
  localparam int ADDR_W = 8;
  localparam logic [ADDR_W-1:0] A_FLT   = 8'h0A;
  localparam logic [ADDR_W-1:0] A_MODE  = 8'h12;
  localparam logic [ADDR_W-1:0] A_REMAP = 8'h26;
  localparam logic [ADDR_W-1:0] A_ALLOC = 8'h29;
  localparam logic [ADDR_W-1:0] A_REV   = 8'h41;
  localparam logic [ADDR_W-1:0] A_CTL   = 8'h60;

  typedef enum logic [1:0] {
    CH_OFF    = 2'b00,
    CH_MANUAL = 2'b01,
    CH_SEMI   = 2'b10,
    CH_AUTO   = 2'b11
  } ch_mode_e;
endpackage

// File: rtl/sm_parity_chk.sv
module sm_parity_chk #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] rd_data,
  input  logic              rd_par,
  input  logic              rd_vld,
  output logic              par_err
);
  // even parity: total ones over data plus parity bit must be even
  assign par_err = rd_vld & (^{rd_data, rd_par});
endmodule

// File: rtl/sm_ctrl.sv
module sm_ctrl #(
  parameter int REJ_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             par_err,
  input  logic             wr_ctl,
  input  logic [1:0]       wr_ctl_bits,
  input  logic             wr_flt_clr,
  input  logic             rej_evt,
  output logic             fault,
  output logic             enter,
  output logic             safe_q,
  output logic             ram_en_q,
  output logic             par_en_q,
  output logic             flt_q,
  output logic [REJ_W-1:0] rej_q
);
  assign fault = par_err & par_en_q;
  assign enter = fault & ~safe_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      safe_q   <= 1'b0;
      ram_en_q <= 1'b0;
      par_en_q <= 1'b0;
      flt_q    <= 1'b0;
      rej_q    <= '0;
    end else begin
      if (wr_ctl) par_en_q <= wr_ctl_bits[1];

      if (fault)       ram_en_q <= 1'b0;
      else if (wr_ctl) ram_en_q <= wr_ctl_bits[0];

      if (fault)                         safe_q <= 1'b1;
      else if (wr_ctl && wr_ctl_bits[0]) safe_q <= 1'b0;

      if (fault)           flt_q <= 1'b1;
      else if (wr_flt_clr) flt_q <= 1'b0;

      if (rej_evt && !(&rej_q)) rej_q <= rej_q + 1'b1;
    end
  end
endmodule

// File: rtl/sm_chan.sv
module sm_chan (
  input  logic       clk,
  input  logic       rst,
  input  logic       enter,
  input  logic       safe,
  input  logic       wr_mode,
  input  logic [1:0] wmode,
  input  logic       pwr,
  output logic [1:0] mode,
  output logic       en
);
  import sm_pkg::*;
  logic frozen_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      frozen_q <= 1'b0;
      mode     <= CH_OFF;
    end else if (enter) begin
      frozen_q <= pwr;
      if (!pwr) mode <= CH_OFF;
    end else if (wr_mode) begin
      mode <= wmode;
    end
  end

  assign en = ~safe | frozen_q;
endmodule

// File: rtl/safemode_sup.sv
module safemode_sup #(
  parameter int              NUM_CH = 4,
  parameter int              DATA_W = 8,
  parameter int              REJ_W  = 4,
  parameter logic [DATA_W-1:0] FW_REV = 8'h3A
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [7:0]          host_addr,
  input  logic [DATA_W-1:0]   host_wdata,
  input  logic                host_we,
  output logic [DATA_W-1:0]   host_rdata,
  input  logic [DATA_W-1:0]   mem_rd_data,
  input  logic                mem_rd_par,
  input  logic                mem_rd_vld,
  input  logic [NUM_CH-1:0]   ch_pwr,
  output logic [2*NUM_CH-1:0] ch_mode,
  output logic [NUM_CH-1:0]   ch_en,
  output logic                safe_mode,
  output logic [REJ_W-1:0]    rej_cnt
);
  import sm_pkg::*;
  localparam int MODE_W = 2 * NUM_CH;
  localparam int PAD_W  = MODE_W + DATA_W;
  localparam logic [DATA_W-1:0] REMAP_RST = 8'hE4;

  logic par_err, fault, enter, safe_q, ram_en_q, par_en_q, flt_q;
  logic acc_ok, wr_ctl, wr_flt_clr, wr_mode, wr_remap, wr_alloc, rej_evt;
  logic [DATA_W-1:0] remap_q, alloc_q, rd_nxt;
  logic [PAD_W-1:0]  wpad, mpad;

  sm_parity_chk #(.DATA_W(DATA_W)) u_par (
    .rd_data(mem_rd_data), .rd_par(mem_rd_par), .rd_vld(mem_rd_vld), .par_err(par_err)
  );

  // in safe mode only the control and fault registers accept writes
  assign acc_ok     = ~safe_q || host_addr == A_CTL || host_addr == A_FLT;
  assign rej_evt    = host_we & ~acc_ok;
  assign wr_ctl     = host_we && host_addr == A_CTL;
  assign wr_flt_clr = host_we && host_addr == A_FLT && host_wdata[0];
  assign wr_mode    = host_we && acc_ok && host_addr == A_MODE;
  assign wr_remap   = host_we && acc_ok && host_addr == A_REMAP;
  assign wr_alloc   = host_we && acc_ok && host_addr == A_ALLOC;

  sm_ctrl #(.REJ_W(REJ_W)) u_ctrl (
    .clk(clk), .rst(rst), .par_err(par_err), .wr_ctl(wr_ctl),
    .wr_ctl_bits(host_wdata[1:0]), .wr_flt_clr(wr_flt_clr), .rej_evt(rej_evt),
    .fault(fault), .enter(enter), .safe_q(safe_q), .ram_en_q(ram_en_q),
    .par_en_q(par_en_q), .flt_q(flt_q), .rej_q(rej_cnt)
  );

  assign wpad = {{MODE_W{1'b0}}, host_wdata};

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    sm_chan u_chan (
      .clk(clk), .rst(rst), .enter(enter), .safe(safe_q), .wr_mode(wr_mode),
      .wmode(wpad[2*i +: 2]), .pwr(ch_pwr[i]),
      .mode(ch_mode[2*i +: 2]), .en(ch_en[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      remap_q <= REMAP_RST;
      alloc_q <= '0;
    end else begin
      if (wr_remap) remap_q <= host_wdata;
      if (wr_alloc) alloc_q <= host_wdata;
    end
  end

  assign mpad = {{DATA_W{1'b0}}, ch_mode};

  always_comb begin
    rd_nxt = '0;
    case (host_addr)
      A_FLT:   rd_nxt[0] = flt_q;
      A_MODE:  rd_nxt = mpad[DATA_W-1:0];
      A_REMAP: rd_nxt = remap_q;
      A_ALLOC: rd_nxt = alloc_q;
      A_REV:   rd_nxt = safe_q ? '1 : FW_REV;
      A_CTL:   rd_nxt[1:0] = {par_en_q, ram_en_q};
      default: rd_nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) host_rdata <= '0;
    else     host_rdata <= rd_nxt;
  end

  assign safe_mode = safe_q;
endmodule

// File: rtl/sm_checker.sv
module sm_checker #(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 8,
  parameter int REJ_W  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [7:0]        host_addr,
  input logic [DATA_W-1:0] host_wdata,
  input logic              host_we,
  input logic [DATA_W-1:0] host_rdata,
  input logic [DATA_W-1:0] mem_rd_data,
  input logic              mem_rd_par,
  input logic              mem_rd_vld,
  input logic              safe_mode,
  input logic [NUM_CH-1:0] ch_en,
  input logic [REJ_W-1:0]  rej_cnt,
  input logic              par_en_q,
  input logic              flt_q
);
  p_enter_r1: assert property (@(posedge clk) disable iff (rst)
    (par_en_q && mem_rd_vld && (^{mem_rd_data, mem_rd_par})) |=> (safe_mode && flt_q));

  p_ignore_r2: assert property (@(posedge clk) disable iff (rst)
    (!safe_mode && (!par_en_q || !mem_rd_vld)) |=> !safe_mode);

  p_rev_r4: assert property (@(posedge clk) disable iff (rst)
    (host_addr == 8'h41 && safe_mode) |=> host_rdata == '1);

  p_freeze_r5: assert property (@(posedge clk) disable iff (rst)
    ($past(safe_mode) && safe_mode) |-> $stable(ch_en));

  p_exit_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(safe_mode) |-> $past(host_we && host_addr == 8'h60 && host_wdata[0]));

  p_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(flt_q) |-> $past(host_we && host_addr == 8'h0A && host_wdata[0]));

  p_reject_r9: assert property (@(posedge clk) disable iff (rst)
    (safe_mode && host_we && host_addr != 8'h60 && host_addr != 8'h0A)
      |=> (rej_cnt == REJ_W'($past(rej_cnt) + 1'b1)) || (&$past(rej_cnt)));
endmodule

bind safemode_sup sm_checker #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .REJ_W(REJ_W)) u_chk (
  .clk(clk), .rst(rst), .host_addr(host_addr), .host_wdata(host_wdata),
  .host_we(host_we), .host_rdata(host_rdata), .mem_rd_data(mem_rd_data),
  .mem_rd_par(mem_rd_par), .mem_rd_vld(mem_rd_vld), .safe_mode(safe_mode),
  .ch_en(ch_en), .rej_cnt(rej_cnt), .par_en_q(par_en_q), .flt_q(flt_q)
);

// File: tb/tb_safemode_sup.sv
module tb_safemode_sup;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] REV = 8'h3A;

  logic clk = 1'b0, rst = 1'b1;
  logic [7:0] host_addr = '0, host_wdata = '0, host_rdata, mem_rd_data = '0;
  logic host_we = 1'b0, mem_rd_par = 1'b0, mem_rd_vld = 1'b0, safe_mode;
  logic [3:0] ch_pwr = '0, ch_en, rej_cnt;
  logic [7:0] ch_mode;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  safemode_sup #(.NUM_CH(4), .DATA_W(8), .REJ_W(4), .FW_REV(REV)) dut (
    .clk(clk), .rst(rst), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_we(host_we), .host_rdata(host_rdata), .mem_rd_data(mem_rd_data),
    .mem_rd_par(mem_rd_par), .mem_rd_vld(mem_rd_vld), .ch_pwr(ch_pwr),
    .ch_mode(ch_mode), .ch_en(ch_en), .safe_mode(safe_mode), .rej_cnt(rej_cnt)
  );

  // parity vectors: {data, parity bit, expected fault}
  localparam logic [9:0] PVEC [8] = '{
    {8'h00, 1'b0, 1'b0}, {8'h00, 1'b1, 1'b1}, {8'h01, 1'b1, 1'b0}, {8'h01, 1'b0, 1'b1},
    {8'hFF, 1'b0, 1'b0}, {8'h7F, 1'b1, 1'b0}, {8'h7F, 1'b0, 1'b1}, {8'hA5, 1'b0, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    host_addr = a; host_wdata = d; host_we = 1'b1;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    host_addr = a; host_we = 1'b0;
    @(negedge clk);
    d = host_rdata;
  endtask

  task automatic mread(input logic [7:0] d, input logic p, input logic v);
    mem_rd_data = d; mem_rd_par = p; mem_rd_vld = v;
    @(negedge clk);
    mem_rd_vld = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R10 reset state
    chk("R10 safe", safe_mode, 0);
    chk("R10 ch_en", ch_en, 4'hF);
    chk("R10 mode", ch_mode, 8'h00);
    chk("R10 rej", rej_cnt, 0);
    rd(8'h26, r); chk("R10 remap", r, 8'hE4);
    rd(8'h60, r); chk("R10 ctl", r, 8'h00);
    rd(8'h41, r); chk("R4 R11 rev normal", r, REV);

    // R2 armed off: bad parity ignored
    mread(8'h00, 1'b1, 1'b1);
    chk("R2 unarmed", safe_mode, 0);
    rd(8'h0A, r); chk("R2 flag", r, 8'h00);

    // R1 vector table
    for (int i = 0; i < 8; i++) begin
      wr(8'h0A, 8'h01);
      wr(8'h60, 8'h03);
      mread(PVEC[i][9:2], PVEC[i][1], 1'b1);
      chk("R1 parity safe", safe_mode, PVEC[i][0]);
      rd(8'h0A, r); chk("R1 parity flag", r, {7'd0, PVEC[i][0]});
    end

    // R2 strobe low
    mread(8'h00, 1'b1, 1'b0);
    chk("R2 strobe low", safe_mode, 0);

    // set up configuration, then fault
    wr(8'h12, 8'hE7);
    wr(8'h26, 8'h1B);
    wr(8'h29, 8'h5A);
    ch_pwr = 4'b0101;
    mread(8'h01, 1'b0, 1'b1);
    chk("R3 safe", safe_mode, 1);
    rd(8'h60, r); chk("R3 ctl ram_en cleared", r, 8'h02);
    rd(8'h0A, r); chk("R3 flag", r, 8'h01);
    rd(8'h41, r); chk("R4 rev safe", r, 8'hFF);
    chk("R5 mode forced", ch_mode, 8'h23);
    chk("R5 en", ch_en, 4'b0101);
    ch_pwr = 4'hF;
    @(negedge clk);
    chk("R5 en frozen", ch_en, 4'b0101);

    // R9 rejected writes
    wr(8'h26, 8'hFF);
    chk("R9 rej 1", rej_cnt, 1);
    wr(8'h12, 8'hFF);
    chk("R9 rej 2", rej_cnt, 2);
    chk("R9 mode kept", ch_mode, 8'h23);
    rd(8'h26, r); chk("R9 R6 remap kept", r, 8'h1B);
    rd(8'h29, r); chk("R6 alloc kept", r, 8'h5A);

    // R7 exit only with bit 0
    wr(8'h60, 8'h02);
    chk("R7 no exit", safe_mode, 1);
    host_addr = 8'h60; host_wdata = 8'h03; host_we = 1'b1;
    mread(8'h00, 1'b1, 1'b1);
    host_we = 1'b0;
    chk("R7 fault beats exit", safe_mode, 1);
    wr(8'h60, 8'h03);
    chk("R7 exit", safe_mode, 0);
    chk("R7 en restored", ch_en, 4'hF);
    rd(8'h41, r); chk("R4 rev after", r, REV);
    rd(8'h26, r); chk("R6 remap after", r, 8'h1B);

    // R8 sticky flag
    rd(8'h0A, r); chk("R8 sticky", r, 8'h01);
    wr(8'h0A, 8'h00);
    rd(8'h0A, r); chk("R8 write zero", r, 8'h01);
    wr(8'h0A, 8'h01);
    rd(8'h0A, r); chk("R8 cleared", r, 8'h00);
    host_addr = 8'h0A; host_wdata = 8'h01; host_we = 1'b1;
    mread(8'h00, 1'b1, 1'b1);
    host_we = 1'b0;
    rd(8'h0A, r); chk("R8 fault beats clear", r, 8'h01);

    // R9 saturation (now in safe mode)
    for (int k = 0; k < 16; k++) wr(8'h29, 8'h00);
    chk("R9 saturate", rej_cnt, 4'hF);

    // R10 reset from safe mode
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    chk("R10 safe cleared", safe_mode, 0);
    chk("R10 rej cleared", rej_cnt, 0);
    chk("R10 mode cleared", ch_mode, 8'h00);
    rd(8'h0A, r); chk("R10 flag cleared", r, 8'h00);
    rd(8'h26, r); chk("R10 remap reset", r, 8'hE4);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule